// File: doc/BRIEF.md
# Three-Wire Synthesiser Programming Interface

This block takes the serial programming stream of a dual frequency synthesiser (a data line, a bit clock and a strobe line) and turns it into the set of working fields that the dividers, the fractional accumulator and the charge-pump control consume. Bits arrive least significant first while the strobe is low. The rising edge of the strobe closes a frame. The block counts the bits of that frame, classifies the word by its leading bits and the stored word-length mode, and commits the fields. A word that fails this check is thrown away.

Frequency words come in two lengths: a 24-bit short form and a 32-bit long form that also carries a current scaling byte. A stored mode bit selects which of the two is expected. The prescaler word does not reach the working registers directly: it is held in a staging register and applied together with the next accepted frequency word, so that a four-modulus retune takes effect at one instant. While the strobe stays high after an accepted frequency word, a speed-up flag is raised. Bit-clock pulses seen during a high strobe are ignored.

The bus inputs are asynchronous to the system clock. They are passed through a synchroniser and then edge-detected inside the block.

Top module: `syn_prog_if`

## Requirements
- R1: After reset every field output is zero except main_off and aux_off, which are 1, and speedup is 0.
- R2: A frame of exactly 24 bits whose final (most significant) bit is 0 is accepted as a short frequency word only while long_mode is 0. Word bit 23 is 0, bits 22:20 go to frac_inc, bits 19:8 to cnt_first, and bits 7:0 to cnt_second.
- R3: A frame of exactly 32 bits whose bit 31 is 0 is accepted as a long frequency word only while long_mode is 1. Bits 30:28 go to frac_inc, bits 27:16 to cnt_first, bits 15:8 to cnt_second, and bits 7:0 to gain_code.
- R4: A 24-bit frame with bits 23:20 = 1010 is the reference word. Bits 19:8 go to ref_div, 7:6 to main_tap, 5 to main_off, 4:3 to aux_tap, 2 to aux_off, 1 to frac_mod8 and 0 to long_mode. main_off and aux_off change on no other word.
- R5: A 24-bit frame with bits 23:20 = 1001 is the auxiliary word. Bits 19:8 go to aux_div and bits 7:0 are ignored.
- R6: A 24-bit frame with bits 23:20 = 1000 is the prescaler word: cnt_last_sum is bits 19:16, gain_code is bits 15:8, int_gain is bits 7:4, prop_shift is bits 3:2 and modulus_sel is bits 1:0. It changes no output when it is loaded. It is applied once, by the next accepted frequency word, and a long word's own gain_code byte overrides the staged one.
- R7: A frame is discarded with no output change if its bit count is not 24 or 32, if its 24-bit prefix is 1011 or 11xx, or if its length does not match long_mode.
- R8: speedup rises after the strobe edge that commits a frequency word and stays high while the strobe is high. It falls within a few cycles of the strobe going low. No other word raises it.
- R9: Bit-clock pulses while the strobe is high neither shift data nor count bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_data | input | 1 | Serial data, least significant bit first |
| ser_stb | input | 1 | Strobe, low while shifting, rising edge commits |
| frac_inc | output | 3 | Fractional accumulator increment |
| cnt_first | output | 12 | Cycle count for the first prescaler ratio |
| cnt_second | output | 8 | Second ratio count, or split count pair |
| cnt_last_sum | output | 4 | Modulo-16 running sum for the fourth ratio |
| gain_code | output | 8 | Current scaling byte |
| int_gain | output | 4 | Integral pump acceleration factor |
| prop_shift | output | 2 | Proportional pump acceleration exponent |
| modulus_sel | output | 2 | Prescaler modulus count (00 two, 01 three, 10 four) |
| ref_div | output | 12 | Reference divider ratio |
| main_tap | output | 2 | Reference tap for the main loop |
| main_off | output | 1 | Main synthesiser disabled |
| aux_tap | output | 2 | Reference tap for the auxiliary loop |
| aux_off | output | 1 | Auxiliary synthesiser disabled |
| frac_mod8 | output | 1 | Fractional modulus: 0 is five, 1 is eight |
| long_mode | output | 1 | Long frequency word expected |
| aux_div | output | 12 | Auxiliary divider ratio |
| speedup | output | 1 | Speed-up interval active |

## Verification
The assertions assume that the bus runs much slower than the system clock. Each bus level must hold for several system cycles, so that every bit-clock and strobe edge survives the synchroniser as a separate edge and data is stable when the rising edge is detected. The bench drives each bus phase for at least three system cycles and changes data only while the bit clock is low. The strobe rises only after the last bit-clock pulse has ended. The random frames mix all five word types, unknown prefixes and lengths off by one, so that the discard path and the staging path are both exercised against the bench's own model.

// File: rtl/syn_prog_pkg.sv
package syn_prog_pkg;

    localparam int SHIFT_W   = 32;
    localparam int CNT_W     = 6;
    localparam int SHORT_LEN = 24;
    localparam int LONG_LEN  = 32;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_SHORT,
        KIND_LONG,
        KIND_PRESC,
        KIND_AUX,
        KIND_REF
    } word_kind_t;

    typedef struct packed {
        logic [2:0]  frac_inc;
        logic [11:0] cnt_first;
        logic [7:0]  cnt_second;
        logic [3:0]  cnt_last_sum;
        logic [7:0]  gain_code;
        logic [3:0]  int_gain;
        logic [1:0]  prop_shift;
        logic [1:0]  modulus_sel;
        logic [11:0] ref_div;
        logic [1:0]  main_tap;
        logic        main_off;
        logic [1:0]  aux_tap;
        logic        aux_off;
        logic        frac_mod8;
        logic        long_mode;
        logic [11:0] aux_div;
    } work_regs_t;

    typedef struct packed {
        logic [3:0] cnt_last_sum;
        logic [7:0] gain_code;
        logic [3:0] int_gain;
        logic [1:0] prop_shift;
        logic [1:0] modulus_sel;
    } stage_regs_t;

endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    assign chain_d[0] = din;

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            assign chain_d[g] = chain_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/prog_shifter.sv
module prog_shifter
    import syn_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_rise,
    input  logic               bit_val,
    input  logic               hold,
    input  logic               clr,
    output logic [SHIFT_W-1:0] sr,
    output logic [CNT_W-1:0]   cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [SHIFT_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clr) begin
            sh_d.cnt = '0;
        end else if (bit_rise && !hold) begin
            // new bit enters at the top: the last bit of a frame ends at bit 31
            sh_d.sr = {bit_val, sh_q.sr[SHIFT_W-1:1]};
            if (sh_q.cnt != CNT_MAX) sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sr  = sh_q.sr;
    assign cnt = sh_q.cnt;

    AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(sr)); // R9
    AST_HOLD_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(cnt)); // R9
endmodule

// File: rtl/prog_decode.sv
module prog_decode
    import syn_prog_pkg::*;
(
    input  logic [3:0]       prefix,
    input  logic [CNT_W-1:0] cnt,
    input  logic             long_mode,
    output word_kind_t       kind
);
    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(SHORT_LEN);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(LONG_LEN);

    always_comb begin
        kind = KIND_NONE;
        if (cnt == LEN_S) begin
            if (!prefix[3]) begin
                kind = long_mode ? KIND_NONE : KIND_SHORT;
            end else begin
                unique case (prefix)
                    4'b1010: kind = KIND_REF;
                    4'b1000: kind = KIND_PRESC;
                    4'b1001: kind = KIND_AUX;
                    default: kind = KIND_NONE;
                endcase
            end
        end else if (cnt == LEN_L && !prefix[3] && long_mode) begin
            kind = KIND_LONG;
        end
    end
endmodule

// File: rtl/syn_prog_if.sv
module syn_prog_if
    import syn_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_stb,
    output logic [2:0]  frac_inc,
    output logic [11:0] cnt_first,
    output logic [7:0]  cnt_second,
    output logic [3:0]  cnt_last_sum,
    output logic [7:0]  gain_code,
    output logic [3:0]  int_gain,
    output logic [1:0]  prop_shift,
    output logic [1:0]  modulus_sel,
    output logic [11:0] ref_div,
    output logic [1:0]  main_tap,
    output logic        main_off,
    output logic [1:0]  aux_tap,
    output logic        aux_off,
    output logic        frac_mod8,
    output logic        long_mode,
    output logic [11:0] aux_div,
    output logic        speedup
);
    typedef struct packed {
        work_regs_t  w;
        stage_regs_t stg;
        logic        pend;
        logic        spd;
        logic        clk_prev;
        logic        stb_prev;
    } st_t;

    st_t q, nx;

    logic [2:0]         bus_s;
    logic               clk_rise, stb_rise, stb_lvl;
    logic [SHIFT_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;
    word_kind_t         kind;
    logic               commit_freq, commit_presc, commit_ref, commit_none;

    prog_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_stb, ser_data, ser_clk}),
        .dout (bus_s)
    );

    assign stb_lvl  = bus_s[2];
    assign clk_rise = bus_s[0] & ~q.clk_prev;
    assign stb_rise = bus_s[2] & ~q.stb_prev;

    prog_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_rise(clk_rise),
        .bit_val (bus_s[1]),
        .hold    (stb_lvl),
        .clr     (stb_rise),
        .sr      (sr),
        .cnt     (cnt)
    );

    prog_decode u_dec (
        .prefix   (sr[SHIFT_W-1 -: 4]),
        .cnt      (cnt),
        .long_mode(q.w.long_mode),
        .kind     (kind)
    );

    always_comb begin
        nx           = q;
        nx.clk_prev  = bus_s[0];
        nx.stb_prev  = bus_s[2];
        commit_freq  = 1'b0;
        commit_presc = 1'b0;
        commit_ref   = 1'b0;
        commit_none  = 1'b0;
        if (stb_rise) begin
            unique case (kind)
                KIND_SHORT, KIND_LONG: begin
                    commit_freq     = 1'b1;
                    nx.w.frac_inc   = sr[30:28];
                    nx.w.cnt_first  = sr[27:16];
                    nx.w.cnt_second = sr[15:8];
                    if (q.pend) begin
                        nx.w.cnt_last_sum = q.stg.cnt_last_sum;
                        nx.w.gain_code    = q.stg.gain_code;
                        nx.w.int_gain     = q.stg.int_gain;
                        nx.w.prop_shift   = q.stg.prop_shift;
                        nx.w.modulus_sel  = q.stg.modulus_sel;
                        nx.pend           = 1'b0;
                    end
                    if (kind == KIND_LONG) nx.w.gain_code = sr[7:0];
                    nx.spd = 1'b1;
                end
                KIND_PRESC: begin
                    commit_presc         = 1'b1;
                    nx.stg.cnt_last_sum  = sr[27:24];
                    nx.stg.gain_code     = sr[23:16];
                    nx.stg.int_gain      = sr[15:12];
                    nx.stg.prop_shift    = sr[11:10];
                    nx.stg.modulus_sel   = sr[9:8];
                    nx.pend              = 1'b1;
                end
                KIND_AUX: begin
                    nx.w.aux_div = sr[27:16];
                end
                KIND_REF: begin
                    commit_ref     = 1'b1;
                    nx.w.ref_div   = sr[27:16];
                    nx.w.main_tap  = sr[15:14];
                    nx.w.main_off  = sr[13];
                    nx.w.aux_tap   = sr[12:11];
                    nx.w.aux_off   = sr[10];
                    nx.w.frac_mod8 = sr[9];
                    nx.w.long_mode = sr[8];
                end
                default: commit_none = 1'b1;
            endcase
        end
        if (!stb_lvl) nx.spd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.w.main_off <= 1'b1;
            q.w.aux_off  <= 1'b1;
        end else begin
            q <= nx;
        end
    end

    assign frac_inc     = q.w.frac_inc;
    assign cnt_first    = q.w.cnt_first;
    assign cnt_second   = q.w.cnt_second;
    assign cnt_last_sum = q.w.cnt_last_sum;
    assign gain_code    = q.w.gain_code;
    assign int_gain     = q.w.int_gain;
    assign prop_shift   = q.w.prop_shift;
    assign modulus_sel  = q.w.modulus_sel;
    assign ref_div      = q.w.ref_div;
    assign main_tap     = q.w.main_tap;
    assign main_off     = q.w.main_off;
    assign aux_tap      = q.w.aux_tap;
    assign aux_off      = q.w.aux_off;
    assign frac_mod8    = q.w.frac_mod8;
    assign long_mode    = q.w.long_mode;
    assign aux_div      = q.w.aux_div;
    assign speedup      = q.spd;

    AST_SPD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_lvl |=> !speedup); // R8
    AST_SPD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(speedup) |-> $past(commit_freq)); // R8
    AST_PRESC_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        commit_presc |=> ($stable(gain_code) && $stable(int_gain) && $stable(modulus_sel))); // R6
    AST_OFF_ONLY_REF: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_ref |=> ($stable(main_off) && $stable(aux_off))); // R4
    AST_DISCARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        commit_none |=> $stable(q.w)); // R7
endmodule

// File: tb/sim_syn_prog_if.sv
`timescale 1ns/1ps
module sim_syn_prog_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_stb = 1'b0;
    logic [2:0]  frac_inc;
    logic [11:0] cnt_first, ref_div, aux_div;
    logic [7:0]  cnt_second, gain_code;
    logic [3:0]  cnt_last_sum, int_gain;
    logic [1:0]  prop_shift, modulus_sel, main_tap, aux_tap;
    logic        main_off, aux_off, frac_mod8, long_mode, speedup;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    syn_prog_if u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_stb(ser_stb),
        .frac_inc(frac_inc), .cnt_first(cnt_first), .cnt_second(cnt_second),
        .cnt_last_sum(cnt_last_sum), .gain_code(gain_code), .int_gain(int_gain),
        .prop_shift(prop_shift), .modulus_sel(modulus_sel), .ref_div(ref_div),
        .main_tap(main_tap), .main_off(main_off), .aux_tap(aux_tap), .aux_off(aux_off),
        .frac_mod8(frac_mod8), .long_mode(long_mode), .aux_div(aux_div), .speedup(speedup)
    );

    // bench model of the working and staged fields
    logic [2:0]  e_nf;   logic [11:0] e_n1;  logic [7:0] e_n2;  logic [3:0] e_n234;
    logic [7:0]  e_cn;   logic [3:0]  e_k;   logic [1:0] e_l;   logic [1:0] e_mod;
    logic [11:0] e_nr;   logic [1:0]  e_mt;  logic e_mo;        logic [1:0] e_at;
    logic        e_ao;   logic e_f8;  logic e_lm; logic [11:0] e_na;
    logic [3:0]  s_n234; logic [7:0] s_cn; logic [3:0] s_k; logic [1:0] s_l, s_mod;
    logic        s_pend;

    task automatic model_reset();
        e_nf = 0; e_n1 = 0; e_n2 = 0; e_n234 = 0; e_cn = 0; e_k = 0; e_l = 0; e_mod = 0;
        e_nr = 0; e_mt = 0; e_mo = 1; e_at = 0; e_ao = 1; e_f8 = 0; e_lm = 0; e_na = 0;
        s_n234 = 0; s_cn = 0; s_k = 0; s_l = 0; s_mod = 0; s_pend = 0;
    endtask

    // returns 1 when the frame is an accepted frequency word
    function automatic bit model_apply(input logic [31:0] w, input int n);
        bit freq = 0;
        bit lng = 0;
        if (n == 24 && !w[23] && !e_lm) freq = 1;
        else if (n == 32 && !w[31] && e_lm) begin freq = 1; lng = 1; end
        else if (n == 24 && w[23:20] == 4'b1010) begin
            e_nr = w[19:8]; e_mt = w[7:6]; e_mo = w[5]; e_at = w[4:3];
            e_ao = w[2]; e_f8 = w[1]; e_lm = w[0];
        end else if (n == 24 && w[23:20] == 4'b1001) begin
            e_na = w[19:8];
        end else if (n == 24 && w[23:20] == 4'b1000) begin
            s_n234 = w[19:16]; s_cn = w[15:8]; s_k = w[7:4]; s_l = w[3:2]; s_mod = w[1:0];
            s_pend = 1;
        end
        if (freq) begin
            if (lng) begin e_nf = w[30:28]; e_n1 = w[27:16]; e_n2 = w[15:8]; end
            else     begin e_nf = w[22:20]; e_n1 = w[19:8];  e_n2 = w[7:0];  end
            if (s_pend) begin
                e_n234 = s_n234; e_cn = s_cn; e_k = s_k; e_l = s_l; e_mod = s_mod; s_pend = 0;
            end
            if (lng) e_cn = w[7:0];
        end
        return freq;
    endfunction

    function automatic logic [31:0] mk_short(input logic [2:0] nf, input logic [11:0] n1, input logic [7:0] n2);
        return {8'h00, 1'b0, nf, n1, n2};
    endfunction
    function automatic logic [31:0] mk_long(input logic [2:0] nf, input logic [11:0] n1, input logic [7:0] n2, input logic [7:0] cn);
        return {1'b0, nf, n1, n2, cn};
    endfunction
    function automatic logic [31:0] mk_ref(input logic [11:0] nr, input logic [7:0] flags);
        return {8'h00, 4'b1010, nr, flags};
    endfunction
    function automatic logic [31:0] mk_presc(input logic [3:0] n234, input logic [7:0] cn, input logic [3:0] k, input logic [1:0] l, input logic [1:0] m);
        return {8'h00, 4'b1000, n234, cn, k, l, m};
    endfunction
    function automatic logic [31:0] mk_aux(input logic [11:0] na, input logic [7:0] junk);
        return {8'h00, 4'b1001, na, junk};
    endfunction

    task automatic check_fields(input string tag);
        logic [74:0] got, exp;
        got = {frac_inc, cnt_first, cnt_second, cnt_last_sum, gain_code, int_gain, prop_shift,
               modulus_sel, ref_div, main_tap, main_off, aux_tap, aux_off, frac_mod8, long_mode, aux_div};
        exp = {e_nf, e_n1, e_n2, e_n234, e_cn, e_k, e_l, e_mod, e_nr, e_mt, e_mo, e_at, e_ao,
               e_f8, e_lm, e_na};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s fields actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_spd(input string tag, input logic exp);
        checks++;
        if (speedup !== exp) begin
            failures++;
            $display("FAIL %s speedup actual=%b expected=%b", tag, speedup, exp);
        end
    endtask

    task automatic bus_pulse(input logic b);
        ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // sends n bits LSB first, raises strobe, checks speed-up, lowers strobe, checks fields
    task automatic frame(input logic [31:0] w, input int n, input int extra, input string tag);
        bit acc;
        for (int i = 0; i < n; i++) bus_pulse(w[i]);
        repeat (3) @(negedge clk);
        ser_stb = 1'b1;
        acc = model_apply(w, n);
        repeat (8) @(negedge clk);
        for (int i = 0; i < extra; i++) bus_pulse(1'b1);
        check_spd({tag, " R8 during strobe"}, acc);
        ser_stb = 1'b0;
        repeat (8) @(negedge clk);
        check_spd({tag, " R8 after strobe"}, 1'b0);
        check_fields(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_fields("R1 reset");
        check_spd("R1 reset", 1'b0);

        frame(mk_ref(12'h3A5, 8'b10_0_01_1_1_0), 24, 0, "R4 reference word");
        frame(mk_short(3'd3, 12'd51, 8'd25), 24, 0, "R2 short word");
        frame(mk_aux(12'hBEE, 8'hFF), 24, 0, "R5 aux word");
        frame(mk_presc(4'hC, 8'h5A, 4'h9, 2'b11, 2'b10), 24, 0, "R6 prescaler staged");
        frame(mk_short(3'd5, 12'hFFF, 8'h00), 24, 0, "R6 staged applied");
        frame(mk_presc(4'h1, 8'h11, 4'h2, 2'b01, 2'b01), 24, 0, "R6 second stage");
        frame(mk_ref(12'h010, 8'b00_1_00_0_0_1), 24, 0, "R4 long mode on");
        frame(mk_short(3'd1, 12'h123, 8'h45), 24, 0, "R7 short in long mode");
        frame(mk_long(3'd7, 12'h800, 8'h81, 8'hE7), 32, 0, "R3 long overrides gain R6");
        frame(mk_long(3'd2, 12'h001, 8'h02, 8'h33), 32, 0, "R3 no second apply R6");
        frame(mk_ref(12'hFFF, 8'hFF), 23, 0, "R7 short length");
        frame(mk_aux(12'h777, 8'h00), 25, 0, "R7 long length");
        frame({8'h00, 4'b1011, 20'h12345}, 24, 0, "R7 unknown prefix");
        frame({8'h00, 4'b1100, 20'h54321}, 24, 0, "R7 prefix 11xx");
        frame(mk_long(3'd4, 12'h444, 8'h44, 8'h44), 32, 5, "R9 pulses in strobe");
        frame(mk_aux(12'h5C3, 8'h0F), 24, 0, "R9 frame after pulses");

        for (int it = 0; it < 110; it++) begin
            logic [31:0] w;
            int n, kindsel;
            kindsel = int'($urandom_range(0, 5));
            w = $urandom();
            case (kindsel)
                0: begin w = mk_short(w[2:0], w[14:3], w[22:15]); n = 24; end
                1: begin w = mk_long(w[2:0], w[14:3], w[22:15], w[30:23]); n = 32; end
                2: begin w = mk_presc(w[3:0], w[11:4], w[15:12], w[17:16], w[19:18]); n = 24; end
                3: begin w = mk_aux(w[11:0], w[19:12]); n = 24; end
                4: begin w = mk_ref(w[11:0], w[19:12]); n = 24; end
                default: n = ($urandom_range(0, 1) == 0) ? 24 : 32;
            endcase
            if ($urandom_range(0, 7) == 0) n = n + (($urandom_range(0, 1) == 0) ? -1 : 1);
            frame(w, n, int'($urandom_range(0, 3) == 0), "R2 R3 R6 R7 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule